// File: doc/BRIEF.md
# Reset and Wake Cause Recorder

This block keeps a small set of status flags that let firmware work out why the processor last restarted or woke. It takes single-cycle event pulses from around the core. These are power-on, supply brown-out, a reset instruction, the external clear pin, a watchdog expiry, a stack overflow or underflow, and an interrupt that ends a low-power state. Each event changes the flags by its own rule. Some flags are set, some are cleared and the rest are left alone. The clear-pin and watchdog rules also depend on the power mode reported with the event.

The same event also decides the next program address. It raises a one-cycle load strobe together with a 16-bit target. The target is the reset vector, the current address plus two, or one of two interrupt vectors. Firmware can write the software-writable flags back through a synchronous write port. A hardware event in the same cycle wins over that write. All outputs are registered and hold their values while no event is present.

Top module: `rst_cause_tracker`

## Requirements
- R1: Flag vector layout is bit0 instr_n, bit1 wdt_n, bit2 pwrdn_n, bit3 por_n, bit4 bor_n, bit5 ovf, bit6 unf. During and after synchronous reset, flags = 7'b0000111, pc_load = 0 and pc_target = 0000h.
- R2: A power-on event drives flags to 7'b0000111. It pulses pc_load with target 0000h.
- R3: A brown-out event sets bits 0 to 2 and clears bit 4, leaves bits 3, 5 and 6 unchanged, and reloads 0000h.
- R4: A reset-instruction event clears bit 0 only and reloads 0000h.
- R5: A clear-pin event reloads 0000h in every mode, with pwr_mode encoded as 0 full, 1 low-power run, 2 idle, 3 sleep. In mode 1 it sets bit 1. In mode 2 or 3 it sets bit 1 and clears bit 2. In mode 0 it changes no flag.
- R6: A watchdog event in mode 0 or 1 clears bit 1 and reloads 0000h.
- R7: A watchdog event in mode 2 or 3 clears bits 1 and 2 and loads pc_cur + 2.
- R8: Overflow sets bit 5 and underflow sets bit 6. A reload to 0000h follows only when stk_rst_en = 1; otherwise pc_load stays 0 and pc_target holds.
- R9: An interrupt wake clears bit 2 and pulses pc_load. The target is 0008h when gie_hi = 1, else 0018h when gie_lo = 1, else pc_cur + 2.
- R10: When several events coincide, only the highest applies, in the order power-on, brown-out, clear-pin, watchdog, overflow, underflow, reset instruction, interrupt wake.
- R11: With sw_we = 1 and no event, bits 0, 3, 4, 5 and 6 take sw_wdata, and bits 1 and 2 are unchanged. Any event in the same cycle discards the write.
- R12: In a cycle with no event, pc_load is 0 the next cycle and pc_target holds, so the strobe lasts exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_por | input | 1 | Power-on event pulse |
| ev_bor | input | 1 | Brown-out event pulse |
| ev_mclr | input | 1 | External clear-pin event pulse |
| ev_wdt | input | 1 | Watchdog expiry pulse |
| ev_ovf | input | 1 | Stack overflow pulse |
| ev_unf | input | 1 | Stack underflow pulse |
| ev_instr | input | 1 | Reset instruction pulse |
| ev_irq_wake | input | 1 | Interrupt wake pulse |
| pwr_mode | input | 2 | Power mode: 0 full, 1 run, 2 idle, 3 sleep |
| stk_rst_en | input | 1 | Stack faults cause a reset |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| pc_cur | input | 16 | Current program address |
| sw_we | input | 1 | Software flag write enable |
| sw_wdata | input | 7 | Software flag write data |
| flags | output | 7 | Registered status flags |
| pc_load | output | 1 | One-cycle program address load strobe |
| pc_target | output | 16 | Address to load |

## Verification
Directed cases apply each event alone, starting from flag values that differ from the event's own pattern, so that set, clear and unchanged bits can each be told apart. The clear-pin and watchdog events are swept across all four power modes. This separates the reset path from the resume-at-plus-two path. The wake event is tried with each combination of the two interrupt enables to tell the three targets apart. Random cycles with sparse and coinciding pulses, random modes and random software writes check the priority order and the rule that an event overrides a write.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int FLAG_W     = 7;
  localparam int NUM_CAUSES = 8;

  localparam int F_INSTR_N = 0;
  localparam int F_WDT_N   = 1;
  localparam int F_PWRDN_N = 2;
  localparam int F_POR_N   = 3;
  localparam int F_BOR_N   = 4;
  localparam int F_OVF     = 5;
  localparam int F_UNF     = 6;

  localparam logic [FLAG_W-1:0] SW_MASK =
    FLAG_W'((1 << F_INSTR_N) | (1 << F_POR_N) | (1 << F_BOR_N) |
            (1 << F_OVF) | (1 << F_UNF));

  localparam logic [FLAG_W-1:0] FLAGS_COLD =
    FLAG_W'((1 << F_INSTR_N) | (1 << F_WDT_N) | (1 << F_PWRDN_N));

  // cause value i+1 corresponds to request bit i (bit 0 highest priority)
  typedef enum logic [3:0] {
    CAUSE_NONE  = 4'd0,
    CAUSE_POR   = 4'd1,
    CAUSE_BOR   = 4'd2,
    CAUSE_MCLR  = 4'd3,
    CAUSE_WDT   = 4'd4,
    CAUSE_OVF   = 4'd5,
    CAUSE_UNF   = 4'd6,
    CAUSE_INSTR = 4'd7,
    CAUSE_WAKE  = 4'd8
  } cause_e;

  typedef enum logic [1:0] {
    PM_FULL  = 2'd0,
    PM_RUN   = 2'd1,
    PM_IDLE  = 2'd2,
    PM_SLEEP = 2'd3
  } pmode_e;
endpackage

// File: rtl/rst_cause_arbiter.sv
module rst_cause_arbiter
  import rst_cause_pkg::*;
#(
  parameter int N = NUM_CAUSES
) (
  input  logic [N-1:0] req,
  output cause_e       sel
);
  always_comb begin
    sel = CAUSE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) sel = cause_e'(4'(i + 1));
    end
  end
endmodule

// File: rtl/rst_cause_flag_rules.sv
module rst_cause_flag_rules
  import rst_cause_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  cause_e            sel,
  input  pmode_e            mode,
  input  logic              sw_we,
  input  logic [FLAG_W-1:0] sw_wdata,
  output logic [FLAG_W-1:0] nxt
);
  logic low_power;
  assign low_power = (mode == PM_IDLE) || (mode == PM_SLEEP);

  always_comb begin
    nxt = cur;
    case (sel)
      CAUSE_NONE: begin
        if (sw_we) nxt = (cur & ~SW_MASK) | (sw_wdata & SW_MASK);
      end
      CAUSE_POR: nxt = FLAGS_COLD;
      CAUSE_BOR: begin
        nxt[F_INSTR_N] = 1'b1;
        nxt[F_WDT_N]   = 1'b1;
        nxt[F_PWRDN_N] = 1'b1;
        nxt[F_BOR_N]   = 1'b0;
      end
      CAUSE_MCLR: begin
        if (mode != PM_FULL) nxt[F_WDT_N] = 1'b1;
        if (low_power)       nxt[F_PWRDN_N] = 1'b0;
      end
      CAUSE_WDT: begin
        nxt[F_WDT_N] = 1'b0;
        if (low_power) nxt[F_PWRDN_N] = 1'b0;
      end
      CAUSE_OVF:   nxt[F_OVF] = 1'b1;
      CAUSE_UNF:   nxt[F_UNF] = 1'b1;
      CAUSE_INSTR: nxt[F_INSTR_N] = 1'b0;
      CAUSE_WAKE:  nxt[F_PWRDN_N] = 1'b0;
      default:     nxt = cur;
    endcase
  end
endmodule

// File: rtl/rst_cause_target.sv
module rst_cause_target
  import rst_cause_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0,
  parameter logic [ADDR_W-1:0]  VEC_HI    = ADDR_W'(8),
  parameter logic [ADDR_W-1:0]  VEC_LO    = ADDR_W'(24),
  parameter int                 PC_STEP   = 2
) (
  input  cause_e             sel,
  input  pmode_e             mode,
  input  logic               stk_rst_en,
  input  logic               gie_hi,
  input  logic               gie_lo,
  input  logic [ADDR_W-1:0]  pc_cur,
  output logic               load,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] pc_next;
  assign pc_next = pc_cur + ADDR_W'(PC_STEP);

  always_comb begin
    load = 1'b1;
    addr = RESET_VEC;
    case (sel)
      CAUSE_NONE: load = 1'b0;
      CAUSE_WDT: begin
        if (mode == PM_IDLE || mode == PM_SLEEP) addr = pc_next;
      end
      CAUSE_OVF, CAUSE_UNF: load = stk_rst_en;
      CAUSE_WAKE: begin
        if (gie_hi)      addr = VEC_HI;
        else if (gie_lo) addr = VEC_LO;
        else             addr = pc_next;
      end
      default: addr = RESET_VEC;
    endcase
  end
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rst_cause_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0,
  parameter logic [ADDR_W-1:0]  VEC_HI    = ADDR_W'(8),
  parameter logic [ADDR_W-1:0]  VEC_LO    = ADDR_W'(24),
  parameter int                 PC_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_por,
  input  logic              ev_bor,
  input  logic              ev_mclr,
  input  logic              ev_wdt,
  input  logic              ev_ovf,
  input  logic              ev_unf,
  input  logic              ev_instr,
  input  logic              ev_irq_wake,
  input  logic [1:0]        pwr_mode,
  input  logic              stk_rst_en,
  input  logic              gie_hi,
  input  logic              gie_lo,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic              sw_we,
  input  logic [6:0]        sw_wdata,
  output logic [6:0]        flags,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target
);
  logic [NUM_CAUSES-1:0] req;
  cause_e                sel;
  pmode_e                mode;
  logic [FLAG_W-1:0]     flags_nxt;
  logic                  load_nxt;
  logic [ADDR_W-1:0]     addr_nxt;

  assign req  = {ev_irq_wake, ev_instr, ev_unf, ev_ovf,
                 ev_wdt, ev_mclr, ev_bor, ev_por};
  assign mode = pmode_e'(pwr_mode);

  rst_cause_arbiter #(.N(NUM_CAUSES)) u_arb (
    .req (req),
    .sel (sel)
  );

  rst_cause_flag_rules u_rules (
    .cur      (flags),
    .sel      (sel),
    .mode     (mode),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .nxt      (flags_nxt)
  );

  rst_cause_target #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .VEC_HI    (VEC_HI),
    .VEC_LO    (VEC_LO),
    .PC_STEP   (PC_STEP)
  ) u_tgt (
    .sel        (sel),
    .mode       (mode),
    .stk_rst_en (stk_rst_en),
    .gie_hi     (gie_hi),
    .gie_lo     (gie_lo),
    .pc_cur     (pc_cur),
    .load       (load_nxt),
    .addr       (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= FLAGS_COLD;
      pc_load   <= 1'b0;
      pc_target <= RESET_VEC;
    end else begin
      flags   <= flags_nxt;
      pc_load <= load_nxt;
      if (load_nxt) pc_target <= addr_nxt;
    end
  end
endmodule

// File: rtl/rst_cause_checker.sv
module rst_cause_checker #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter logic [ADDR_W-1:0] VEC_HI    = ADDR_W'(8)
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_por,
  input logic              ev_bor,
  input logic              ev_mclr,
  input logic              ev_wdt,
  input logic              ev_ovf,
  input logic              ev_unf,
  input logic              ev_instr,
  input logic              ev_irq_wake,
  input logic              stk_rst_en,
  input logic              gie_hi,
  input logic [6:0]        flags,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_target
);
  logic any_ev;
  assign any_ev = ev_por | ev_bor | ev_mclr | ev_wdt | ev_ovf |
                  ev_unf | ev_instr | ev_irq_wake;

  assert_cold_values_R2: assert property (@(posedge clk) disable iff (rst)
    ev_por |=> (flags == 7'b0000111 && pc_load && pc_target == RESET_VEC));

  assert_instr_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_instr && !ev_por && !ev_bor && !ev_mclr && !ev_wdt && !ev_ovf && !ev_unf)
    |=> (!flags[0] && pc_load && pc_target == RESET_VEC));

  assert_unf_error_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_unf && !stk_rst_en && !ev_por && !ev_bor && !ev_mclr && !ev_wdt && !ev_ovf)
    |=> (flags[6] && !pc_load));

  assert_wake_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_irq_wake && gie_hi && !(ev_por | ev_bor | ev_mclr | ev_wdt | ev_ovf | ev_unf | ev_instr))
    |=> (pc_load && pc_target == VEC_HI && !flags[2]));

  assert_ro_bits_R11: assert property (@(posedge clk) disable iff (rst)
    !any_ev |=> $stable(flags[2:1]));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !any_ev |=> (!pc_load && $stable(pc_target)));
endmodule

bind rst_cause_tracker rst_cause_checker #(
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC),
  .VEC_HI    (VEC_HI)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_por      (ev_por),
  .ev_bor      (ev_bor),
  .ev_mclr     (ev_mclr),
  .ev_wdt      (ev_wdt),
  .ev_ovf      (ev_ovf),
  .ev_unf      (ev_unf),
  .ev_instr    (ev_instr),
  .ev_irq_wake (ev_irq_wake),
  .stk_rst_en  (stk_rst_en),
  .gie_hi      (gie_hi),
  .flags       (flags),
  .pc_load     (pc_load),
  .pc_target   (pc_target)
);

// File: tb/test_rst_cause_tracker.sv
`timescale 1ns/1ps
module test_rst_cause_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic        ev_por, ev_bor, ev_mclr, ev_wdt, ev_ovf, ev_unf, ev_instr, ev_irq_wake;
  logic [1:0]  pwr_mode;
  logic        stk_rst_en, gie_hi, gie_lo, sw_we;
  logic [15:0] pc_cur;
  logic [6:0]  sw_wdata;
  logic [6:0]  flags;
  logic        pc_load;
  logic [15:0] pc_target;

  int n_tests = 0;
  int n_fail  = 0;
  logic [6:0]  exp_flags;
  logic [15:0] exp_tgt;

  always #4 clk = ~clk;

  rst_cause_tracker i_rst_cause_tracker (
    .clk(clk), .rst(rst), .ev_por(ev_por), .ev_bor(ev_bor), .ev_mclr(ev_mclr),
    .ev_wdt(ev_wdt), .ev_ovf(ev_ovf), .ev_unf(ev_unf), .ev_instr(ev_instr),
    .ev_irq_wake(ev_irq_wake), .pwr_mode(pwr_mode), .stk_rst_en(stk_rst_en),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .pc_cur(pc_cur), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .flags(flags), .pc_load(pc_load), .pc_target(pc_target)
  );

  task automatic check(string req, logic [6:0] f, logic ld, logic [15:0] t);
    n_tests++;
    if (flags !== f || pc_load !== ld || pc_target !== t) begin
      n_fail++;
      $display("FAIL %s: flags=%b load=%b target=%h expected flags=%b load=%b target=%h",
               req, flags, pc_load, pc_target, f, ld, t);
    end
  endtask

  // ev bit order: 0 por,1 bor,2 mclr,3 wdt,4 ovf,5 unf,6 instr,7 wake
  task automatic step(logic [7:0] ev, logic [1:0] mode, logic stk, logic ghi,
                      logic glo, logic [15:0] pc, logic swe, logic [6:0] swd);
    logic [6:0]  f;
    logic        ld;
    logic [15:0] t;
    string       req;
    @(negedge clk);
    {ev_irq_wake, ev_instr, ev_unf, ev_ovf, ev_wdt, ev_mclr, ev_bor, ev_por} = ev;
    pwr_mode = mode; stk_rst_en = stk; gie_hi = ghi; gie_lo = glo;
    pc_cur = pc; sw_we = swe; sw_wdata = swd;
    f = exp_flags; ld = 1'b0; t = exp_tgt; req = "R12";
    if (ev[0]) begin
      f = 7'b0000111; ld = 1'b1; t = 16'h0000; req = "R2";
    end else if (ev[1]) begin
      f[2:0] = 3'b111; f[4] = 1'b0; ld = 1'b1; t = 16'h0000; req = "R3";
    end else if (ev[2]) begin
      if (mode == 2'd1) f[1] = 1'b1;
      else if (mode >= 2'd2) begin f[1] = 1'b1; f[2] = 1'b0; end
      ld = 1'b1; t = 16'h0000; req = "R5";
    end else if (ev[3]) begin
      f[1] = 1'b0; ld = 1'b1;
      if (mode >= 2'd2) begin f[2] = 1'b0; t = pc + 16'd2; req = "R7"; end
      else begin t = 16'h0000; req = "R6"; end
    end else if (ev[4] || ev[5]) begin
      if (ev[4]) f[5] = 1'b1; else f[6] = 1'b1;
      if (stk) begin ld = 1'b1; t = 16'h0000; end
      req = "R8";
    end else if (ev[6]) begin
      f[0] = 1'b0; ld = 1'b1; t = 16'h0000; req = "R4";
    end else if (ev[7]) begin
      f[2] = 1'b0; ld = 1'b1;
      t = ghi ? 16'h0008 : (glo ? 16'h0018 : pc + 16'd2); req = "R9";
    end else if (swe) begin
      f = {swd[6:3], f[2:1], swd[0]}; req = "R11";
    end
    if ($countones(ev) > 1) req = "R10";
    if (ev != 8'd0 && swe) req = {req, "/R11"};
    @(posedge clk);
    #2;
    check(req, f, ld, t);
    exp_flags = f; exp_tgt = t;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    {ev_irq_wake, ev_instr, ev_unf, ev_ovf, ev_wdt, ev_mclr, ev_bor, ev_por} = '0;
    pwr_mode = 2'd0; stk_rst_en = 1'b0; gie_hi = 1'b0; gie_lo = 1'b0;
    pc_cur = 16'h0100; sw_we = 1'b0; sw_wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 7'b0000111, 1'b0, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    exp_flags = 7'b0000111; exp_tgt = 16'h0000;
    step(8'h00, 0, 0, 0, 0, 16'h0100, 0, 7'h00);            // R1/R12 idle
    // R11: write all writable bits to 1 (set por_n, bor_n, ovf, unf)
    step(8'h00, 0, 0, 0, 0, 16'h0100, 1, 7'h7F);
    step(8'h40, 0, 0, 0, 0, 16'h0100, 0, 7'h00);            // R4
    step(8'h00, 0, 0, 0, 0, 16'h0100, 0, 7'h00);            // R12 strobe drops
    step(8'h02, 0, 0, 0, 0, 16'h0100, 0, 7'h00);            // R3
    step(8'h00, 0, 0, 0, 0, 16'h0100, 1, 7'h00);            // R11 clear writable
    for (int m = 0; m < 4; m++) begin
      step(8'h08, 2'(m), 0, 0, 0, 16'h1230 + 16'(m), 0, 7'h00); // R6/R7
      step(8'h04, 2'(m), 0, 0, 0, 16'h2000, 0, 7'h00);          // R5
    end
    step(8'h10, 0, 0, 0, 0, 16'h0300, 0, 7'h00);            // R8 ovf no reset
    step(8'h20, 0, 0, 0, 0, 16'h0300, 0, 7'h00);            // R8 unf error
    step(8'h00, 0, 0, 0, 0, 16'h0300, 1, 7'h19);            // R11
    step(8'h10, 0, 1, 0, 0, 16'h0300, 0, 7'h00);            // R8 ovf reset
    step(8'h20, 0, 1, 0, 0, 16'h0300, 0, 7'h00);            // R8 unf reset
    step(8'h80, 3, 0, 1, 1, 16'h0400, 0, 7'h00);            // R9 hi
    step(8'h80, 2, 0, 0, 1, 16'h0400, 0, 7'h00);            // R9 lo
    step(8'h80, 2, 0, 0, 0, 16'hFFFE, 0, 7'h00);            // R9 resume, wrap
    step(8'hC1, 0, 0, 0, 0, 16'h0500, 0, 7'h00);            // R10 por wins
    step(8'h48, 3, 0, 0, 0, 16'h0500, 0, 7'h00);            // R10 wdt over instr
    step(8'h02, 0, 0, 0, 0, 16'h0500, 1, 7'h00);            // R11 event beats write
    step(8'h00, 0, 0, 0, 0, 16'h0500, 0, 7'h00);            // R12
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev;
      ev = '0;
      for (int b = 0; b < 8; b++) ev[b] = (($urandom % 12) == 0);
      step(ev, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom), (($urandom % 3) == 0), 7'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule